// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Core

This block is a 32-bit in-order processor core that runs each instruction through five stages: fetch, decode with register read, execute, memory access and write-back. Four pipeline registers separate the stages, and a new instruction enters every cycle. The core has no forwarding and no interlocks. Software must keep enough independent work between dependent instructions: a register result is visible to the fourth instruction after its producer and not earlier, and the three instructions after a branch always run, whether or not the branch is taken.

Instruction memory and data memory are word arrays inside the top module. While reset is held, a loader port fills them. Once reset is released, the core fetches from address 0. The register-file write port, the data-memory write port and the fetch PC are driven out as observation outputs, so an external model can follow the core cycle by cycle.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 and `rf_we_o` and `dm_we_o` are low. The pipeline holds only bubbles and all registers read 0. A loader write (`ld_we`) stores `ld_data` at word `ld_addr`: in data memory when `ld_dmem` is 1, otherwise in instruction memory.
- R2: Fetch reads the instruction word indexed by `pc[7:2]` (the index wraps). In each cycle with no taken branch in the memory stage, the PC advances by 4. The first edge after reset fetches address 0.
- R3: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and imm [15:0]. Opcode 0x00 selects an ALU operation, 0x23 a load, 0x2B a store and 0x04 branch-if-equal. Any other opcode, and any other funct under opcode 0x00, writes nothing.
- R4: The ALU functs are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, and 0x2A set-if-less-than (signed, result 1 or 0). The result goes to rd.
- R5: A load reads the data word at `(rs + sext(imm))[7:2]` and writes it to rt.
- R6: A store writes rt to the data word at `(rs + sext(imm))[7:2]`. `dm_we_o`, `dm_addr_o` (the full byte address) and `dm_wdata_o` show the write in the cycle before the edge that performs it.
- R7: Branch-if-equal compares rs and rt by subtraction. When they are equal, the target is `PC+4 + (sext(imm) << 2)` and is loaded into the PC from the memory stage. For a branch fetched at edge n, the instructions fetched at edges n+1 to n+3 still run, and `pc_o` holds the target after edge n+4.
- R8: An instruction reads a register value only if the value was written by an instruction at least four places older. A read in the same cycle as the write to that register returns the old value.
- R9: Register 0 reads as 0. A write to register 0 is dropped and never raises `rf_we_o`.
- R10: An instruction fetched at edge n shows its register write on the `rf_*` outputs after edge n+4 and its store on the `dm_*` outputs after edge n+3. This gives one completion per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loader active while high |
| ld_we | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 1 data memory, 0 instruction memory |
| ld_addr | input | 6 | Loader word address |
| ld_data | input | 32 | Loader word |
| pc_o | output | 32 | Current fetch PC |
| rf_we_o | output | 1 | Register write happening at the next edge |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | Data-memory write happening at the next edge |
| dm_addr_o | output | 32 | Byte address of the store |
| dm_wdata_o | output | 32 | Store data |

## Verification
The hardest cases to reach are a second taken branch inside the three-instruction shadow of the first, and a load or ALU result that lands on the same edge as a read of that register. In these cases the redirect order and the stale-value window both matter. Random programs draw every register from a pool of eight and use short branch offsets, which makes overlapping redirects and same-edge read/write pairs common. Directed programs place a load exactly one to four slots ahead of its consumers and a taken branch at a known slot.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OP_ALU   = 6'h00;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        K_NOP    = 3'd0,
        K_ALU    = 3'd1,
        K_LOAD   = 3'd2,
        K_STORE  = 3'd3,
        K_BRANCH = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        kind_e            kind;
        alu_op_e          op;
        logic             use_imm;
        logic             wr_en;
        logic [RAW-1:0]   dest;
        logic [RAW-1:0]   rs;
        logic [RAW-1:0]   rt;
        logic [XLEN-1:0]  imm;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  instr;
        logic [XLEN-1:0]  pc4;
    } ifid_t;

    typedef struct packed {
        kind_e            kind;
        alu_op_e          op;
        logic             use_imm;
        logic             wr_en;
        logic [RAW-1:0]   dest;
        logic [XLEN-1:0]  imm;
        logic [XLEN-1:0]  pc4;
        logic [XLEN-1:0]  a;
        logic [XLEN-1:0]  b;
    } idex_t;

    typedef struct packed {
        kind_e            kind;
        logic             wr_en;
        logic [RAW-1:0]   dest;
        logic [XLEN-1:0]  y;
        logic [XLEN-1:0]  sdata;
        logic             take;
        logic [XLEN-1:0]  target;
    } exmem_t;

    typedef struct packed {
        logic             wr_en;
        logic [RAW-1:0]   dest;
        logic [XLEN-1:0]  data;
    } memwb_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic             valid,
    input  logic [XLEN-1:0]  instr,
    output ctrl_t            ctrl
);

    logic [5:0] opcode;
    logic [5:0] funct;

    assign opcode = instr[31:26];
    assign funct  = instr[5:0];

    always_comb begin
        ctrl         = '0;
        ctrl.kind    = K_NOP;
        ctrl.op      = ALU_ADD;
        ctrl.rs      = instr[25:21];
        ctrl.rt      = instr[20:16];
        ctrl.imm     = {{(XLEN-16){instr[15]}}, instr[15:0]};
        if (valid) begin
            unique case (opcode)
                OP_ALU: begin
                    ctrl.dest = instr[15:11];
                    unique case (funct)
                        FN_ADD:  begin ctrl.kind = K_ALU; ctrl.op = ALU_ADD; end
                        FN_SUB:  begin ctrl.kind = K_ALU; ctrl.op = ALU_SUB; end
                        FN_AND:  begin ctrl.kind = K_ALU; ctrl.op = ALU_AND; end
                        FN_OR:   begin ctrl.kind = K_ALU; ctrl.op = ALU_OR;  end
                        FN_SLT:  begin ctrl.kind = K_ALU; ctrl.op = ALU_SLT; end
                        default: ctrl.kind = K_NOP;
                    endcase
                end
                OP_LOAD: begin
                    ctrl.kind    = K_LOAD;
                    ctrl.use_imm = 1'b1;
                    ctrl.dest    = instr[20:16];
                end
                OP_STORE: begin
                    ctrl.kind    = K_STORE;
                    ctrl.use_imm = 1'b1;
                end
                OP_BEQ: begin
                    ctrl.kind = K_BRANCH;
                    ctrl.op   = ALU_SUB;
                end
                default: ctrl.kind = K_NOP;
            endcase
        end
        ctrl.wr_en = ((ctrl.kind == K_ALU) || (ctrl.kind == K_LOAD)) && (ctrl.dest != '0);
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y,
    output logic             zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [AW-1:0]     ra,
    input  logic [AW-1:0]     rb,
    output logic [WIDTH-1:0]  rda,
    output logic [WIDTH-1:0]  rdb
);

    logic [WIDTH-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rda = (ra == '0) ? '0 : regs[ra];
    assign rdb = (rb == '0) ? '0 : regs[rb];

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NREG       = 32,
    localparam int IAW       = $clog2(IMEM_WORDS),
    localparam int DAW       = $clog2(DMEM_WORDS),
    localparam int LAW       = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic              ld_dmem,
    input  logic [LAW-1:0]    ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              rf_we_o,
    output logic [RAW-1:0]    rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              dm_we_o,
    output logic [XLEN-1:0]   dm_addr_o,
    output logic [XLEN-1:0]   dm_wdata_o
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q;
    ifid_t           ifid_q;
    idex_t           idex_q;
    exmem_t          exmem_q;
    memwb_t          memwb_q;

    ctrl_t           ctrl_d;
    logic [XLEN-1:0] rd_a, rd_b;
    logic [XLEN-1:0] fetch_word;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] ex_target;
    logic            mem_take;
    logic [XLEN-1:0] mem_target;
    logic            mem_is_load;
    logic [XLEN-1:0] dm_rdata;

    // ---------------- loader and instruction memory ----------------
    always_ff @(posedge clk) begin
        if (rst && ld_we && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
    end

    assign fetch_word = imem[pc_q[IAW+1:2]];

    // ---------------- stage 1: fetch ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (mem_take) begin
            pc_q <= mem_target;
        end else begin
            pc_q <= pc_q + XLEN'(4);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ifid_q <= '0;
        end else begin
            ifid_q.valid <= 1'b1;
            ifid_q.instr <= fetch_word;
            ifid_q.pc4   <= pc_q + XLEN'(4);
        end
    end

    // ---------------- stage 2: decode / register read ----------------
    pipe5_decode u_decode (
        .valid (ifid_q.valid),
        .instr (ifid_q.instr),
        .ctrl  (ctrl_d)
    );

    pipe5_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (memwb_q.wr_en),
        .waddr (memwb_q.dest),
        .wdata (memwb_q.data),
        .ra    (ctrl_d.rs),
        .rb    (ctrl_d.rt),
        .rda   (rd_a),
        .rdb   (rd_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idex_q      <= '0;
            idex_q.kind <= K_NOP;
        end else begin
            idex_q.kind    <= ctrl_d.kind;
            idex_q.op      <= ctrl_d.op;
            idex_q.use_imm <= ctrl_d.use_imm;
            idex_q.wr_en   <= ctrl_d.wr_en;
            idex_q.dest    <= ctrl_d.dest;
            idex_q.imm     <= ctrl_d.imm;
            idex_q.pc4     <= ifid_q.pc4;
            idex_q.a       <= rd_a;
            idex_q.b       <= rd_b;
        end
    end

    // ---------------- stage 3: execute ----------------
    assign alu_b     = idex_q.use_imm ? idex_q.imm : idex_q.b;
    assign ex_target = idex_q.pc4 + (idex_q.imm << 2);

    pipe5_alu u_alu (
        .op   (idex_q.op),
        .a    (idex_q.a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exmem_q      <= '0;
            exmem_q.kind <= K_NOP;
        end else begin
            exmem_q.kind   <= idex_q.kind;
            exmem_q.wr_en  <= idex_q.wr_en;
            exmem_q.dest   <= idex_q.dest;
            exmem_q.y      <= alu_y;
            exmem_q.sdata  <= idex_q.b;
            exmem_q.take   <= (idex_q.kind == K_BRANCH) && alu_zero;
            exmem_q.target <= ex_target;
        end
    end

    // ---------------- stage 4: memory ----------------
    assign mem_take    = exmem_q.take;
    assign mem_target  = exmem_q.target;
    assign mem_is_load = (exmem_q.kind == K_LOAD);
    assign dm_rdata    = dmem[exmem_q.y[DAW+1:2]];

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_we && ld_dmem) dmem[ld_addr[DAW-1:0]] <= ld_data;
        end else if (exmem_q.kind == K_STORE) begin
            dmem[exmem_q.y[DAW+1:2]] <= exmem_q.sdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            memwb_q <= '0;
        end else begin
            memwb_q.wr_en <= exmem_q.wr_en;
            memwb_q.dest  <= exmem_q.dest;
            memwb_q.data  <= mem_is_load ? dm_rdata : exmem_q.y;
        end
    end

    // ---------------- stage 5: write-back and observation ----------------
    assign pc_o       = pc_q;
    assign rf_we_o    = memwb_q.wr_en;
    assign rf_waddr_o = memwb_q.dest;
    assign rf_wdata_o = memwb_q.data;
    assign dm_we_o    = (exmem_q.kind == K_STORE);
    assign dm_addr_o  = exmem_q.y;
    assign dm_wdata_o = exmem_q.sdata;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic        rf_we_o,
    input logic [4:0]  rf_waddr_o,
    input logic [31:0] rf_wdata_o,
    input logic        dm_we_o,
    input logic        mem_take,
    input logic [31:0] mem_target,
    input logic        mem_is_load,
    input logic        mem_wr,
    input logic [31:0] dm_rdata
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pc_o == 32'd0 && !rf_we_o && !dm_we_o)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !mem_take |=> (pc_o == $past(pc_o) + 32'd4)); // R2

    AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        mem_take |=> (pc_o == $past(mem_target))); // R7

    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (mem_is_load && mem_wr) |=> (rf_we_o && rf_wdata_o == $past(dm_rdata))); // R5

    AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |=> !rf_we_o); // R6

    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> (rf_waddr_o != 5'd0)); // R9

endmodule

bind pipe5_core pipe5_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_o        (pc_o),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o),
    .dm_we_o     (dm_we_o),
    .mem_take    (mem_take),
    .mem_target  (mem_target),
    .mem_is_load (mem_is_load),
    .mem_wr      (exmem_q.wr_en),
    .dm_rdata    (dm_rdata)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;

    localparam int IW   = 64;
    localparam int DW   = 64;
    localparam int MAXC = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        dm_we_o;
    logic [31:0] dm_addr_o;
    logic [31:0] dm_wdata_o;

    always #10 clk = ~clk;

    pipe5_core u_dut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    int checks = 0;
    int errors = 0;
    string tag;

    logic [31:0] im [IW];
    logic [31:0] dm [DW];
    logic [31:0] e_pc [MAXC+1];
    logic        e_rfwe [MAXC];
    logic [4:0]  e_rfa [MAXC];
    logic [31:0] e_rfd [MAXC];
    string       e_req [MAXC];
    logic        e_dmwe [MAXC];
    logic [31:0] e_dma [MAXC];
    logic [31:0] e_dmd [MAXC];
    logic        e_take [MAXC];
    logic [31:0] e_tgt [MAXC];

    function automatic logic [31:0] sx(input logic [15:0] i);
        return {{16{i[15]}}, i};
    endfunction

    function automatic logic fn_ok(input logic [5:0] f);
        return (f == 6'h20) || (f == 6'h22) || (f == 6'h24) || (f == 6'h25) || (f == 6'h2A);
    endfunction

    function automatic logic [31:0] alu_ref(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        case (f)
            6'h20:   return a + b;
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] mk_r(input logic [5:0] f, input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, f};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL [%s] %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Program-order model with the visibility rules of R7, R8 and R10.
    task automatic build_model(input int ncyc);
        logic [31:0] regs [32];
        logic [31:0] mdm [DW];
        for (int i = 0; i < 32; i++) regs[i] = '0;
        for (int i = 0; i < DW; i++) mdm[i] = dm[i];
        e_pc[0] = '0;
        for (int n = 0; n < ncyc; n++) begin
            logic [31:0] w, a, b, addr;
            logic [5:0]  op, f;
            logic [4:0]  rs, rt, rd;
            if (n >= 4 && e_rfwe[n-4]) regs[e_rfa[n-4]] = e_rfd[n-4];
            w  = im[e_pc[n][7:2]];
            op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; f = w[5:0];
            a  = regs[rs]; b = regs[rt];
            e_rfwe[n] = 1'b0; e_rfa[n] = '0; e_rfd[n] = '0; e_req[n] = "R4";
            e_dmwe[n] = 1'b0; e_dma[n] = '0; e_dmd[n] = '0;
            e_take[n] = 1'b0; e_tgt[n] = '0;
            addr = a + sx(w[15:0]);
            case (op)
                6'h00: if (fn_ok(f) && rd != 0) begin
                    e_rfwe[n] = 1'b1; e_rfa[n] = rd; e_rfd[n] = alu_ref(f, a, b);
                end
                6'h23: if (rt != 0) begin
                    e_rfwe[n] = 1'b1; e_rfa[n] = rt; e_rfd[n] = mdm[addr[7:2]]; e_req[n] = "R5";
                end
                6'h2B: begin
                    e_dmwe[n] = 1'b1; e_dma[n] = addr; e_dmd[n] = b; mdm[addr[7:2]] = b;
                end
                6'h04: begin
                    e_take[n] = (a == b);
                    e_tgt[n]  = e_pc[n] + 32'd4 + (sx(w[15:0]) << 2);
                end
                default: ;
            endcase
            e_pc[n+1] = (n >= 3 && e_take[n-3]) ? e_tgt[n-3] : e_pc[n] + 32'd4;
        end
    endtask

    task automatic run_prog(input string t, input int ncyc);
        tag = t;
        @(negedge clk);
        rst = 1'b1;
        build_model(ncyc);
        for (int i = 0; i < IW; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = 6'(i); ld_data = im[i];
        end
        for (int i = 0; i < DW; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 6'(i); ld_data = dm[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
        check(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
        check(!rf_we_o, "R1 reset rf_we", 32'(rf_we_o), 32'd0);
        check(!dm_we_o, "R1 reset dm_we", 32'(dm_we_o), 32'd0);
        rst = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            check(pc_o == e_pc[k], "R2 fetch pc", pc_o, e_pc[k]);
            if (k >= 4) begin
                int j;
                j = k - 4;
                check(rf_we_o == e_rfwe[j], {e_req[j], " R10 rf_we"}, 32'(rf_we_o), 32'(e_rfwe[j]));
                if (e_rfwe[j]) begin
                    check(rf_waddr_o == e_rfa[j], {e_req[j], " rf addr"}, 32'(rf_waddr_o), 32'(e_rfa[j]));
                    check(rf_wdata_o == e_rfd[j], {e_req[j], " rf data"}, rf_wdata_o, e_rfd[j]);
                end
            end
            if (k >= 3) begin
                int j;
                j = k - 3;
                check(dm_we_o == e_dmwe[j], "R6 dm_we", 32'(dm_we_o), 32'(e_dmwe[j]));
                if (e_dmwe[j]) begin
                    check(dm_addr_o == e_dma[j], "R6 dm addr", dm_addr_o, e_dma[j]);
                    check(dm_wdata_o == e_dmd[j], "R6 dm data", dm_wdata_o, e_dmd[j]);
                end
            end
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < IW; i++) im[i] = 32'd0;
        for (int i = 0; i < DW; i++) dm[i] = $urandom;
    endtask

    task automatic rand_prog();
        for (int i = 0; i < IW; i++) begin
            int r;
            logic [4:0] rs, rt, rd;
            r  = $urandom_range(0, 99);
            rs = 5'($urandom_range(0, 7));
            rt = 5'($urandom_range(0, 7));
            rd = 5'($urandom_range(0, 7));
            if (r < 40) begin
                logic [5:0] fl [5];
                fl = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
                im[i] = mk_r(fl[$urandom_range(0, 4)], rd, rs, rt);
            end else if (r < 45) im[i] = mk_r(6'h3F, rd, rs, rt);
            else if (r < 65) im[i] = mk_i(6'h23, rt, rs, 16'($urandom_range(0, 255)));
            else if (r < 85) im[i] = mk_i(6'h2B, rt, rs, 16'($urandom_range(0, 255)));
            else if (r < 93) im[i] = mk_i(6'h04, rt, rs, 16'($urandom_range(0, 12)) - 16'd4);
            else im[i] = mk_i(6'h3F, rt, rs, 16'($urandom));
        end
        for (int i = 0; i < DW; i++) dm[i] = ($urandom_range(0, 3) == 0) ? 32'd7 : $urandom;
    endtask

    initial begin
        void'($urandom(32'h0005EED5));
        repeat (3) @(negedge clk);

        // R8: consumers one to four slots after a load
        clear_prog();
        im[0] = mk_i(6'h23, 5'd1, 5'd0, 16'd0);
        im[1] = mk_r(6'h20, 5'd2, 5'd1, 5'd0);
        im[2] = mk_r(6'h20, 5'd3, 5'd1, 5'd0);
        im[3] = mk_r(6'h20, 5'd4, 5'd1, 5'd0);
        im[4] = mk_r(6'h20, 5'd5, 5'd1, 5'd0);
        im[5] = mk_r(6'h25, 5'd6, 5'd5, 5'd4);
        im[9] = mk_i(6'h2B, 5'd6, 5'd0, 16'd8);
        dm[0] = 32'h1357_9BDF;
        run_prog("R8", 40);

        // R7: taken branch, three shadow slots, skipped word, untaken branch
        clear_prog();
        dm[0] = 32'hA5A5_0001; dm[1] = 32'hA5A5_0001;
        im[0]  = mk_i(6'h23, 5'd1, 5'd0, 16'd0);
        im[1]  = mk_i(6'h23, 5'd2, 5'd0, 16'd4);
        im[5]  = mk_i(6'h04, 5'd2, 5'd1, 16'd10);
        im[6]  = mk_r(6'h20, 5'd3, 5'd1, 5'd1);
        im[7]  = mk_r(6'h20, 5'd4, 5'd1, 5'd0);
        im[8]  = mk_r(6'h22, 5'd5, 5'd1, 5'd0);
        im[9]  = mk_r(6'h20, 5'd6, 5'd1, 5'd1);
        im[16] = mk_r(6'h20, 5'd7, 5'd1, 5'd2);
        im[17] = mk_i(6'h04, 5'd0, 5'd1, 16'hFFF0);
        im[18] = mk_i(6'h2B, 5'd7, 5'd0, 16'd12);
        run_prog("R7", 50);

        // R9: register 0 never changes
        clear_prog();
        im[0] = mk_i(6'h23, 5'd1, 5'd0, 16'd0);
        im[4] = mk_r(6'h20, 5'd0, 5'd1, 5'd1);
        im[5] = mk_i(6'h23, 5'd0, 5'd0, 16'd4);
        im[9] = mk_i(6'h2B, 5'd0, 5'd0, 16'd8);
        im[10] = mk_r(6'h20, 5'd4, 5'd0, 5'd1);
        run_prog("R9", 30);

        // R3 and R4: every ALU funct plus undefined encodings
        clear_prog();
        dm[0] = 32'h8000_0005; dm[1] = 32'h0000_0007;
        im[0]  = mk_i(6'h23, 5'd1, 5'd0, 16'd0);
        im[1]  = mk_i(6'h23, 5'd2, 5'd0, 16'd4);
        im[5]  = mk_r(6'h20, 5'd3, 5'd1, 5'd2);
        im[6]  = mk_r(6'h22, 5'd4, 5'd1, 5'd2);
        im[7]  = mk_r(6'h24, 5'd5, 5'd1, 5'd2);
        im[8]  = mk_r(6'h25, 5'd6, 5'd1, 5'd2);
        im[9]  = mk_r(6'h2A, 5'd7, 5'd1, 5'd2);
        im[10] = mk_r(6'h2A, 5'd8, 5'd2, 5'd1);
        im[11] = mk_r(6'h3F, 5'd9, 5'd1, 5'd2);
        im[12] = mk_i(6'h3F, 5'd10, 5'd1, 16'h1234);
        im[13] = mk_i(6'h2B, 5'd8, 5'd0, 16'hFFF8);
        run_prog("R3", 30);

        // R10: random programs, dense branches and register reuse
        for (int p = 0; p < 4; p++) begin
            rand_prog();
            run_prog("R10", 300);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL [watchdog] R10 run did not end actual %0d expected %0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule